// File: doc/BRIEF.md
# Pulse-Shape Trigger Qualifier

This block sits behind a trigger comparator in a sampling front end. It receives the comparator's digitized output and a second qualifier line, both of them asynchronous to the fast sample clock. It emits a single-cycle trigger pulse when the programmed condition holds. The selectable conditions are a plain slope edge, a pulse that is narrower or wider than a limit, a spacing between like edges that is shorter or longer than a limit, a dropout where activity stops for longer than a timeout, and a trigger that is gated by the qualifier line.

After each trigger the block enters a holdoff. The holdoff lasts either a number of clock ticks or a number of trigger-source edges, and the edge count reaches at least 99,999,999. When the holdoff ends, the block re-arms and every measurement starts afresh. Three write-only words configure the block: a control byte, a limit, and a holdoff value. Any write also forces an immediate re-arm.

Top module: `pulse_trig_qual`

## Requirements
- R1: While rst_n is low, and after its release with no trigger activity, trig_out stays low. All configuration words reset to zero, which selects edge mode, positive slope and a time holdoff of zero.
- R2: A write with cfg_we high stores cfg_wdata into a configuration word. Address 0 is control, with bits [2:0] for the mode (0 edge, 1 width, 2 interval, 3 dropout, 4 qualified), bit 3 for negative slope, bit 4 for greater-than compare, bit 5 for holdoff by events, bit 6 for qualifier delay by events and bit 7 for a qualifier transition instead of a qualifier state. Address 1 holds the limit and address 2 holds the holdoff count.
- R3: In edge mode, an active edge on trig_in that is driven just before clock edge k produces trig_out high for exactly one cycle, after clock edge k+2.
- R4: With negative slope, the falling edge of trig_in is the active edge, and a pulse is a low phase of trig_in.
- R5: Width mode fires at the closing edge of a pulse when its width in clock cycles is below the limit (less-than compare) or above the limit (greater-than compare). A width equal to the limit never fires.
- R6: Interval mode fires on an active edge when the number of cycles since the previous active edge compares against the limit under the same rule as R5. Re-arming discards the previous edge.
- R7: Dropout mode fires once when the limit number of cycles has passed with no active edge, counted from the last edge or from the re-arm. Steady activity faster than the limit never fires.
- R8: In qualified mode with state qualification and an event delay, trigger edges that arrive before qual_in is high are ignored. Once qual_in is high, the limit-th active edge fires.
- R9: In qualified mode with transition qualification and a time delay, a rising edge of qual_in starts a cycle count, and the first active edge seen after at least limit cycles fires.
- R10: In time holdoff, a holdoff count of H suppresses every trigger for H+1 cycles after the pulse.
- R11: In event holdoff, a holdoff count of N causes the N active edges that follow a trigger to be ignored. The edge after them may trigger.
- R12: Any configuration write ends a holdoff and re-arms the block. trig_out is low in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Digitized trigger comparator output, asynchronous |
| qual_in | input | 1 | Qualifier line, asynchronous, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| trig_out | output | 1 | Single-cycle trigger pulse |

## Verification
The assertions assume that trig_in and qual_in hold each level for at least one full clock period. Narrower activity could be lost in the synchronizer, and edge-to-output relations would then no longer follow. They also assume that configuration writes are isolated strobes and not held for long stretches, since each write resets the measurement state. The stimulus changes both inputs only on falling clock edges and holds every level for two or more cycles. It issues each write as a one-cycle strobe while the trigger line is idle. It lets the synchronizer settle after any change of slope before it counts pulses.

// File: rtl/trig_qual_pkg.sv
// Shared types for the pulse-shape trigger qualifier.
// Assumes: control word occupies the low eight bits of a configuration write.
package trig_qual_pkg;

    typedef enum logic [2:0] {
        MODE_EDGE     = 3'd0,
        MODE_WIDTH    = 3'd1,
        MODE_INTERVAL = 3'd2,
        MODE_DROPOUT  = 3'd3,
        MODE_QUAL     = 3'd4
    } trig_mode_e;

    localparam logic [1:0] ADDR_CTL   = 2'd0;
    localparam logic [1:0] ADDR_LIMIT = 2'd1;
    localparam logic [1:0] ADDR_HOLD  = 2'd2;

    typedef struct packed {
        logic       qual_trans;
        logic       qual_evt;
        logic       hold_evt;
        logic       cmp_gt;
        logic       neg;
        trig_mode_e mode;
    } ctl_t;

endpackage

// File: rtl/trig_sync_edge.sv
// Synchronizes one asynchronous line and reports its polarity-adjusted
// level plus active and inactive edges.
// Assumes: input levels last at least one clock period; edges are found on
// the raw synchronized value so a polarity change never makes a false edge.
module trig_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic neg,
    output logic lvl,
    output logic act,
    output logic inact
);
    logic [STAGES-1:0] sh;
    logic              prev;
    logic              s;
    logic              rise;
    logic              fall;

    // Shift the input through the synchronizer and keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], async_in};
            prev <= sh[STAGES-1];
        end
    end

    // Derive level and edges relative to the selected polarity.
    always_comb begin
        s     = sh[STAGES-1];
        rise  = s & ~prev;
        fall  = ~s & prev;
        lvl   = s ^ neg;
        act   = neg ? fall : rise;
        inact = neg ? rise : fall;
    end
endmodule

// File: rtl/trig_measure.sv
// Mode engine: one shared counter measures width, interval, dropout time or
// qualifier delay, and raises fire when the programmed condition is met.
// Assumes: run is low during holdoff and on configuration writes; the counter
// is not enabled in edge mode.
module trig_measure
    import trig_qual_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             clear,
    input  ctl_t             ctl,
    input  logic [CNT_W-1:0] limit,
    input  logic             t_lvl,
    input  logic             t_act,
    input  logic             t_inact,
    input  logic             q_lvl,
    input  logic             q_act,
    input  logic             q_inact,
    output logic             fire
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic             seen;
    logic             qok;
    logic             run;
    logic             meets;

    // Saturating increment, run gate and limit comparison.
    always_comb begin
        cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + CNT_ONE;
        run     = armed & ~clear;
        meets   = ctl.cmp_gt ? (cnt > limit) : (cnt < limit);
    end

    // Decide whether this cycle satisfies the selected mode.
    always_comb begin
        fire = 1'b0;
        if (run) begin
            case (ctl.mode)
                MODE_EDGE:     fire = t_act;
                MODE_WIDTH:    fire = t_inact & seen & meets;
                MODE_INTERVAL: fire = t_act & seen & meets;
                MODE_DROPOUT:  fire = ~t_act & (cnt == limit);
                MODE_QUAL:     fire = qok & t_act &
                                      (ctl.qual_evt ? (cnt_inc >= limit) : (cnt >= limit));
                default:       fire = 1'b0;
            endcase
        end
    end

    // Update the shared counter and per-mode flags while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            seen <= 1'b0;
            qok  <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            seen <= 1'b0;
            qok  <= 1'b0;
        end else begin
            case (ctl.mode)
                MODE_WIDTH: begin
                    if (t_act) begin
                        cnt  <= CNT_ONE;
                        seen <= 1'b1;
                    end else if (t_inact) begin
                        seen <= 1'b0;
                    end else if (seen) begin
                        cnt <= cnt_inc;
                    end
                end
                MODE_INTERVAL: begin
                    if (t_act) begin
                        cnt  <= CNT_ONE;
                        seen <= 1'b1;
                    end else if (seen) begin
                        cnt <= cnt_inc;
                    end
                end
                MODE_DROPOUT: cnt <= t_act ? '0 : cnt_inc;
                MODE_QUAL: begin
                    if (!ctl.qual_trans && q_inact) begin
                        qok <= 1'b0;
                        cnt <= '0;
                    end else if (!qok) begin
                        qok <= ctl.qual_trans ? q_act : q_lvl;
                    end else if (!ctl.qual_evt || t_act) begin
                        cnt <= cnt_inc;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/trig_holdoff.sv
// Holdoff sequencer: registers the trigger pulse, then waits a tick count or
// an event count before re-arming.
// Assumes: t_act is the polarity-adjusted active edge of the trigger source.
module trig_holdoff #(
    parameter int HOLD_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rearm,
    input  logic              fire,
    input  logic              t_act,
    input  logic              by_events,
    input  logic [HOLD_W-1:0] hold_val,
    output logic              armed,
    output logic              pulse
);
    typedef enum logic {ST_ARMED, ST_HOLD} hold_st_e;

    hold_st_e          st;
    logic [HOLD_W-1:0] hcnt;
    logic [HOLD_W:0]   hnext;

    // Next event count, one bit wider so it cannot wrap.
    always_comb hnext = {1'b0, hcnt} + (HOLD_W+1)'(1);

    assign armed = (st == ST_ARMED);

    // Issue the pulse and step the holdoff count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_ARMED;
            hcnt  <= '0;
            pulse <= 1'b0;
        end else if (rearm) begin
            st    <= ST_ARMED;
            hcnt  <= '0;
            pulse <= 1'b0;
        end else if (st == ST_ARMED) begin
            pulse <= fire;
            hcnt  <= '0;
            if (fire) st <= ST_HOLD;
        end else begin
            pulse <= 1'b0;
            if (by_events) begin
                if (t_act) begin
                    if (hnext >= {1'b0, hold_val}) st <= ST_ARMED;
                    else hcnt <= hnext[HOLD_W-1:0];
                end
            end else if (hcnt >= hold_val) begin
                st <= ST_ARMED;
            end else begin
                hcnt <= hnext[HOLD_W-1:0];
            end
        end
    end
endmodule

// File: rtl/pulse_trig_qual.sv
// Top of the pulse-shape trigger qualifier: configuration words, input
// synchronizers, mode engine and holdoff sequencer.
// Assumes: CNT_W and HOLD_W do not exceed DATA_W; any write re-arms.
module pulse_trig_qual
    import trig_qual_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int HOLD_W = 27,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              qual_in,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              trig_out
);
    localparam int CTL_W = $bits(ctl_t);

    ctl_t              ctl_q;
    logic [CNT_W-1:0]  limit_q;
    logic [HOLD_W-1:0] hold_q;
    logic              t_lvl, t_act, t_inact;
    logic              q_lvl, q_act, q_inact;
    logic              armed;
    logic              fire;

    // Store configuration words on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            limit_q <= '0;
            hold_q  <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_CTL:   ctl_q   <= ctl_t'(cfg_wdata[CTL_W-1:0]);
                ADDR_LIMIT: limit_q <= cfg_wdata[CNT_W-1:0];
                ADDR_HOLD:  hold_q  <= cfg_wdata[HOLD_W-1:0];
                default: ;
            endcase
        end
    end

    trig_sync_edge #(.STAGES(STAGES)) u_tsync (
        .clk(clk), .rst_n(rst_n), .async_in(trig_in), .neg(ctl_q.neg),
        .lvl(t_lvl), .act(t_act), .inact(t_inact)
    );

    trig_sync_edge #(.STAGES(STAGES)) u_qsync (
        .clk(clk), .rst_n(rst_n), .async_in(qual_in), .neg(1'b0),
        .lvl(q_lvl), .act(q_act), .inact(q_inact)
    );

    trig_measure #(.CNT_W(CNT_W)) u_meas (
        .clk(clk), .rst_n(rst_n), .armed(armed), .clear(cfg_we),
        .ctl(ctl_q), .limit(limit_q),
        .t_lvl(t_lvl), .t_act(t_act), .t_inact(t_inact),
        .q_lvl(q_lvl), .q_act(q_act), .q_inact(q_inact),
        .fire(fire)
    );

    trig_holdoff #(.HOLD_W(HOLD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .rearm(cfg_we), .fire(fire),
        .t_act(t_act), .by_events(ctl_q.hold_evt), .hold_val(hold_q),
        .armed(armed), .pulse(trig_out)
    );
endmodule

// File: rtl/pulse_trig_qual_chk.sv
// Assertion checker for the pulse-shape trigger qualifier, bound to the top.
// Assumes: it observes the top's internal nets through the bind connections.
module pulse_trig_qual_chk
    import trig_qual_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic       trig_out,
    input trig_mode_e mode,
    input logic       hold_evt,
    input logic       armed,
    input logic       t_act,
    input logic       t_inact,
    input logic       fire
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !trig_out);

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);

    // R3
    edge_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_EDGE && armed && t_act && !cfg_we) |=> trig_out);

    // R5
    width_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WIDTH && fire) |-> t_inact);

    // R6
    interval_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INTERVAL && fire) |-> t_act);

    // R11
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_evt && !armed && !t_act && !cfg_we) |=> !armed);

    // R12
    cfg_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !trig_out);
endmodule

bind pulse_trig_qual pulse_trig_qual_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .trig_out(trig_out),
    .mode(ctl_q.mode), .hold_evt(ctl_q.hold_evt), .armed(armed),
    .t_act(t_act), .t_inact(t_inact), .fire(fire)
);

// File: tb/sim_pulse_trig_qual.sv
module sim_pulse_trig_qual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic        qual_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        trig_out;

    int ntotal = 0;
    int nfail  = 0;
    int pcount = 0;

    always #5 clk = ~clk;

    pulse_trig_qual u0 (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .qual_in(qual_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .trig_out(trig_out)
    );

    // Count trigger pulses away from the active edge.
    always @(negedge clk) if (trig_out === 1'b1) pcount++;

    typedef struct packed {
        logic [7:0]  ctl;
        logic [15:0] limit;
        logic [15:0] hold;
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic [7:0]  n;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    // ctl: [2:0] mode, [3] neg, [4] gt, [5] hold by events, [6] qual events, [7] qual transition
    localparam vec_t VECS [14] = '{
        '{8'h00, 16'd0,  16'd0,  8'd3, 8'd10, 8'd5,  8'd5, 8'd3},  // R3 edge
        '{8'h08, 16'd0,  16'd0,  8'd3, 8'd10, 8'd5,  8'd5, 8'd4},  // R4 negative edge
        '{8'h00, 16'd0,  16'd50, 8'd3, 8'd17, 8'd10, 8'd4, 8'd10}, // R10 time holdoff
        '{8'h20, 16'd0,  16'd3,  8'd3, 8'd17, 8'd10, 8'd3, 8'd11}, // R11 event holdoff
        '{8'h01, 16'd4,  16'd0,  8'd2, 8'd10, 8'd3,  8'd3, 8'd5},  // R5 glitch below limit
        '{8'h01, 16'd4,  16'd0,  8'd8, 8'd10, 8'd3,  8'd0, 8'd5},  // R5 wide, lt
        '{8'h11, 16'd4,  16'd0,  8'd8, 8'd10, 8'd3,  8'd3, 8'd5},  // R5 wide, gt
        '{8'h11, 16'd4,  16'd0,  8'd4, 8'd10, 8'd3,  8'd0, 8'd5},  // R5 equal, gt
        '{8'h01, 16'd4,  16'd0,  8'd4, 8'd10, 8'd3,  8'd0, 8'd5},  // R5 equal, lt
        '{8'h09, 16'd4,  16'd0,  8'd2, 8'd10, 8'd3,  8'd3, 8'd4},  // R4 low glitch
        '{8'h02, 16'd10, 16'd0,  8'd2, 8'd4,  8'd4,  8'd2, 8'd6},  // R6 short interval
        '{8'h12, 16'd10, 16'd0,  8'd3, 8'd17, 8'd4,  8'd2, 8'd6},  // R6 long, gt
        '{8'h02, 16'd10, 16'd0,  8'd3, 8'd17, 8'd4,  8'd0, 8'd6},  // R6 long, lt
        '{8'h02, 16'd10, 16'd0,  8'd3, 8'd7,  8'd4,  8'd0, 8'd6}   // R6 equal, lt
    };

    task automatic check(input bit ok, input int req, input string what,
                         input int act, input int exp);
        ntotal++;
        if (!ok) begin
            nfail++;
            $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic config3(input logic [7:0] ctl, input int lim, input int hold);
        wr(2'd0, {24'd0, ctl});  // R2 control at address 0
        wr(2'd1, lim);
        wr(2'd2, hold);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulses(input logic idle, input int hi, input int lo, input int n);
        for (int k = 0; k < n; k++) begin
            trig_in = ~idle;
            repeat (hi) @(negedge clk);
            trig_in = idle;
            repeat (lo) @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v);
        trig_in = v.ctl[3];
        qual_in = 1'b0;
        repeat (6) @(negedge clk);
        config3(v.ctl, int'(v.limit), int'(v.hold));
        pcount = 0;
        pulses(v.ctl[3], int'(v.hi), int'(v.lo), int'(v.n));
        repeat (30) @(negedge clk);
        check(pcount == int'(v.exp), int'(v.req), "pulse count", pcount, int'(v.exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        ntotal++; nfail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("%0d/%0d checks passed", ntotal - nfail, ntotal);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(trig_out == 1'b0, 1, "out in reset", int'(trig_out), 0);
        rst_n = 1'b1;
        pcount = 0;
        repeat (10) @(negedge clk);
        check(pcount == 0, 1, "quiet after reset", pcount, 0);

        // R3 exact latency and width in the reset configuration
        trig_in = 1'b1;
        @(negedge clk); check(trig_out == 1'b0, 3, "lat+1", int'(trig_out), 0);
        @(negedge clk); check(trig_out == 1'b0, 3, "lat+2", int'(trig_out), 0);
        @(negedge clk); check(trig_out == 1'b1, 3, "lat+3", int'(trig_out), 1);
        @(negedge clk); check(trig_out == 1'b0, 3, "lat+4", int'(trig_out), 0);
        trig_in = 1'b0;
        repeat (5) @(negedge clk);

        // Vector table
        for (int i = 0; i < 14; i++) run_vec(VECS[i]);

        // R7 dropout: steady activity, then silence
        trig_in = 1'b0; qual_in = 1'b0;
        repeat (5) @(negedge clk);
        config3(8'h03, 30, 200);
        pcount = 0;
        pulses(1'b0, 3, 17, 5);
        check(pcount == 0, 7, "no dropout while active", pcount, 0);
        repeat (45) @(negedge clk);
        check(pcount == 1, 7, "dropout after silence", pcount, 1);
        repeat (200) @(negedge clk);

        // R8 qualifier state, event delay of 3
        config3(8'h44, 3, 0);
        pcount = 0;
        pulses(1'b0, 3, 7, 3);
        check(pcount == 0, 8, "unqualified edges", pcount, 0);
        qual_in = 1'b1;
        repeat (5) @(negedge clk);
        pulses(1'b0, 3, 7, 2);
        check(pcount == 0, 8, "two qualified edges", pcount, 0);
        pulses(1'b0, 3, 7, 1);
        check(pcount == 1, 8, "third qualified edge", pcount, 1);
        qual_in = 1'b0;
        repeat (10) @(negedge clk);

        // R9 qualifier transition, time delay of 40
        config3(8'h84, 40, 0);
        pcount = 0;
        pulses(1'b0, 3, 7, 2);
        check(pcount == 0, 9, "edges before transition", pcount, 0);
        qual_in = 1'b1;
        repeat (3) @(negedge clk);
        qual_in = 1'b0;
        repeat (5) @(negedge clk);
        pulses(1'b0, 3, 7, 1);
        check(pcount == 0, 9, "edge inside delay", pcount, 0);
        repeat (50) @(negedge clk);
        pulses(1'b0, 3, 7, 1);
        check(pcount == 1, 9, "edge after delay", pcount, 1);

        // R12 write ends a long holdoff
        config3(8'h00, 0, 100000);
        pcount = 0;
        pulses(1'b0, 3, 17, 2);
        check(pcount == 1, 12, "holdoff blocks second edge", pcount, 1);
        wr(2'd0, 32'h0000_0000);
        repeat (3) @(negedge clk);
        pulses(1'b0, 3, 17, 1);
        check(pcount == 2, 12, "write re-arms", pcount, 2);

        $display("%0d/%0d checks passed", ntotal - nfail, ntotal);
        $finish;
    end
endmodule